// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Time Base

This block collects four interrupt sources, masks them with a global enable and per-source enables, and offers the single most urgent one to the CPU as a vector address over a request/acknowledge handshake. Three of the sources are request flags owned by neighbouring logic: external line 0, the counter/timer overflow and external line 1. The fourth is an internal free-running time base that counts machine cycles and raises its own flag on its terminal count.

Arbitration is single-level. The set of pending and enabled sources is sampled once per machine cycle, on the machine-cycle strobe, into a registered candidate. When the CPU acknowledges, the candidate's vector is latched, a one-cycle clear pulse goes back to the owner of the granted flag, and the block enters service. No further request is raised until a return-from-interrupt pulse ends the service. After reset the vector output holds the reset address 000h.

The time base increments once per machine cycle while its run bit is set. Writing 0 to the run bit stops it and returns the count to zero. On the step past its largest value it wraps to zero and sets its flag, which a dedicated clear input or a grant of the time-base source clears.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_req, in_service, src_clr, tb_flag and tb_cnt are all zero, en_q reads 00h and irq_vec holds the reset address 000h.
- R2: A write to the enable register stores bit 7 (global enable) and bits 3..0 (per-source enables: bit 0 external line 0, bit 1 timer overflow, bit 2 external line 1, bit 3 time base); bits 6..4 always read 0 and writing them has no effect.
- R3: While the global enable bit 7 is 0, no interrupt is requested or acknowledged, whatever the per-source enables and flags hold.
- R4: When several enabled sources are pending at one sampling point, the grant goes in the order external line 0, timer overflow, external line 1, time base, with vectors 003h, 00Bh, 013h and 01Bh.
- R5: A request is raised only after a machine-cycle strobe has sampled the pending set; a flag that rises between strobes produces no request until the next strobe.
- R6: An acknowledge while irq_req is high latches the winner's vector on irq_vec, sets in_service, drops irq_req, and pulses exactly the winner's bit of src_clr (bit index = source number of R2) for one clock.
- R7: While in_service is 1, irq_req stays 0 and irq_vec holds; a reti pulse clears in_service, and a still-pending source is requested after the next strobe.
- R8: While the run bit is 1 the time base count rises by one on each strobe and holds between strobes.
- R9: Writing 0 to the run bit stops the time base and clears its count to zero; strobes then leave it at zero.
- R10: A strobe with the count at its largest value (2^CNT_W - 1) wraps the count to zero and sets tb_flag.
- R11: A pulse on tb_flag_clr clears tb_flag, and a grant of the time-base source clears it too.
- R12: A source whose own enable bit is 0 is never requested, even with its flag set and the global enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_q | output | 8 | Enable register contents |
| src_flag | input | NSRC-1 | Request flags: bit 0 external line 0, bit 1 timer overflow, bit 2 external line 1 |
| tb_run_wr | input | 1 | Time-base run bit write strobe |
| tb_run_wdata | input | 1 | Value written to the run bit |
| tb_flag_clr | input | 1 | Clear pulse for the time-base flag |
| tb_cnt | output | CNT_W | Time-base count |
| tb_flag | output | 1 | Time-base terminal-count flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_ack | input | 1 | Acknowledge from the CPU |
| irq_vec | output | VEC_W | Vector address of the granted source |
| in_service | output | 1 | A service is in progress |
| reti | input | 1 | Return-from-interrupt pulse |
| src_clr | output | NSRC | One-clock clear pulse to the owner of the granted flag |

## Verification
The bench builds the block with CNT_W = 5 and every other parameter at its default, so the time base wraps after 32 strobes instead of 1024. That puts the terminal-count carry, the flag clear and a second wrap all within a short run. It also lets the time-base flag and external line 1 be pending at the same sampling point, which tests the lowest two priority levels against each other. Four sources and the default vector base and stride keep the vector values those of the requirements.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // Global enable position in the enable register.
   localparam int unsigned EA_BIT   = 7;
   localparam int unsigned MAX_SRC  = 7;

   typedef logic [2:0] src_idx_t;

   typedef struct packed {
      logic     vld;
      src_idx_t idx;
   } pick_t;

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
   import prio_irq_pkg::*;
#(
   parameter int unsigned NSRC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wd,
   output logic [7:0] q
);

   if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
      $error("irq_enable_reg: NSRC out of range");
   end

   for (genvar g = 0; g < 8; g++) begin : g_bit
      if (g == EA_BIT || g < NSRC) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q[g] <= 1'b0;
            else if (wr)  q[g] <= wd[g];
         end
      end else begin : g_rsvd
         logic unused_bit;
         assign unused_bit = wd[g];
         assign q[g]       = 1'b0;
      end
   end

endmodule

// File: rtl/irq_timebase.sv
module irq_timebase #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_wr,
   input  logic             run_wd,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_w
      $error("irq_timebase: CNT_W must be at least 2");
   end

   logic run;
   logic stop_wr;
   logic step;
   logic carry;

   assign stop_wr = run_wr && !run_wd;
   assign step    = run && tick && !stop_wr;
   assign carry   = step && (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run <= 1'b0;
      else if (run_wr)  run <= run_wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (stop_wr)  cnt <= '0;
      else if (step)     cnt <= cnt + 1'b1;
   end

   // A carry in the same cycle as a clear wins: the event is not lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (carry)     flag <= 1'b1;
      else if (flag_clr)  flag <= 1'b0;
   end

   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !run_wr && cnt != CNT_MAX) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !run_wr) |=> $stable(cnt));

   p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_wr && !run_wd) |=> cnt == '0);

   p_wrap_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !run_wr && cnt == CNT_MAX) |=> (flag && cnt == '0));

   p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !(run && tick && cnt == CNT_MAX)) |=> !flag);

endmodule

// File: rtl/prio_pick.sv
module prio_pick
   import prio_irq_pkg::*;
#(
   parameter int unsigned NSRC      = 4,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic [NSRC-1:0] pend,
   output pick_t           pick
);

   if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
      $error("prio_pick: NSRC out of range");
   end

   if (LSB_FIRST) begin : g_lsb
      // Scan downwards so the lowest set index is written last and wins.
      always_comb begin
         pick = '0;
         for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
               pick.vld = 1'b1;
               pick.idx = src_idx_t'(i);
            end
         end
      end
   end else begin : g_msb
      always_comb begin
         pick = '0;
         for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) begin
               pick.vld = 1'b1;
               pick.idx = src_idx_t'(i);
            end
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NSRC       = 4,
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned VEC_W      = 11,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter bit          LSB_FIRST  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_tick,
   input  logic             en_wr,
   input  logic [7:0]       en_wdata,
   output logic [7:0]       en_q,
   input  logic [NSRC-2:0]  src_flag,
   input  logic             tb_run_wr,
   input  logic             tb_run_wdata,
   input  logic             tb_flag_clr,
   output logic [CNT_W-1:0] tb_cnt,
   output logic             tb_flag,
   output logic             irq_req,
   input  logic             irq_ack,
   output logic [VEC_W-1:0] irq_vec,
   output logic             in_service,
   input  logic             reti,
   output logic [NSRC-1:0]  src_clr
);

   localparam logic [VEC_W-1:0] V_BASE   = VEC_W'(VEC_BASE);
   localparam logic [VEC_W-1:0] V_STRIDE = VEC_W'(VEC_STRIDE);
   localparam int unsigned      TB_SRC   = NSRC - 1;

   if (NSRC < 2 || NSRC > MAX_SRC) begin : g_bad_nsrc
      $error("prio_irq_ctrl: NSRC must be 2..7");
   end
   if (VEC_BASE + VEC_STRIDE * (NSRC - 1) >= (1 << VEC_W)) begin : g_bad_vec
      $error("prio_irq_ctrl: vector table does not fit VEC_W");
   end

   logic [NSRC-1:0] flags_all;
   logic [NSRC-1:0] pend;
   logic            ea;
   pick_t           pick;
   pick_t           cand_q;
   logic            grant;
   logic [VEC_W-1:0] vec_calc;

   irq_enable_reg #(.NSRC(NSRC)) u_en (
      .clk (clk),
      .rst_n (rst_n),
      .wr (en_wr),
      .wd (en_wdata),
      .q (en_q)
   );

   irq_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk (clk),
      .rst_n (rst_n),
      .tick (mc_tick),
      .run_wr (tb_run_wr),
      .run_wd (tb_run_wdata),
      .flag_clr (tb_flag_clr | src_clr[TB_SRC]),
      .cnt (tb_cnt),
      .flag (tb_flag)
   );

   assign ea        = en_q[EA_BIT];
   assign flags_all = {tb_flag, src_flag};
   assign pend      = flags_all & en_q[NSRC-1:0] & {NSRC{ea}};

   prio_pick #(.NSRC(NSRC), .LSB_FIRST(LSB_FIRST)) u_pick (
      .pend (pend),
      .pick (pick)
   );

   // Candidate: refreshed on each machine-cycle strobe outside service,
   // dropped at grant so the same flag cannot be offered twice.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cand_q <= '0;
      else if (grant)                      cand_q <= '0;
      else if (mc_tick && !in_service)     cand_q <= pick;
   end

   assign irq_req  = cand_q.vld && ea && !in_service;
   assign grant    = irq_req && irq_ack;
   assign vec_calc = V_BASE + V_STRIDE * VEC_W'(cand_q.idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      in_service <= 1'b0;
      else if (grant)  in_service <= 1'b1;
      else if (reti)   in_service <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_vec <= '0;
      else if (grant)  irq_vec <= vec_calc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      src_clr <= '0;
      else if (grant)  src_clr <= NSRC'(1) << cand_q.idx;
      else             src_clr <= '0;
   end

   p_ea_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ea && !in_service) |=> !in_service);

   p_req_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(mc_tick) || $past(en_wr)));

   p_grant_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> (in_service && !irq_req && $countones(src_clr) == 1));

   p_clr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_clr));

   p_service_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service && !reti) |=> (in_service && $stable(irq_vec)));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

   localparam int CW   = 5;
   localparam int NS   = 4;
   localparam int VW   = 11;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          mc_tick;
   logic          en_wr;
   logic [7:0]    en_wdata;
   logic [7:0]    en_q;
   logic [NS-2:0] src_flag;
   logic          tb_run_wr;
   logic          tb_run_wdata;
   logic          tb_flag_clr;
   logic [CW-1:0] tb_cnt;
   logic          tb_flag;
   logic          irq_req;
   logic          irq_ack;
   logic [VW-1:0] irq_vec;
   logic          in_service;
   logic          reti;
   logic [NS-1:0] src_clr;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;
   bit  auto_ack = 1'b0;
   int  exp_q[$];

   always #2 clk = ~clk;

   prio_irq_ctrl #(.NSRC(NS), .CNT_W(CW)) u_prio_irq_ctrl (
      .clk (clk), .rst_n (rst_n), .mc_tick (mc_tick),
      .en_wr (en_wr), .en_wdata (en_wdata), .en_q (en_q),
      .src_flag (src_flag), .tb_run_wr (tb_run_wr), .tb_run_wdata (tb_run_wdata),
      .tb_flag_clr (tb_flag_clr), .tb_cnt (tb_cnt), .tb_flag (tb_flag),
      .irq_req (irq_req), .irq_ack (irq_ack), .irq_vec (irq_vec),
      .in_service (in_service), .reti (reti), .src_clr (src_clr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick();
      mc_tick = 1'b1;
      @(negedge clk);
      mc_tick = 1'b0;
   endtask

   task automatic wr_en(input logic [7:0] v);
      en_wr = 1'b1; en_wdata = v;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   task automatic wr_run(input logic v);
      tb_run_wr = 1'b1; tb_run_wdata = v;
      @(negedge clk);
      tb_run_wr = 1'b0;
   endtask

   // Driver: expect one grant of source idx, let the monitor acknowledge it,
   // then check single-level blocking and return from service.
   task automatic serve(input int idx, input string tag);
      exp_q.push_back(idx);
      tick();
      step(3);
      chk({tag, " in_service after grant"}, in_service, 1);
      if (idx < NS - 1) src_flag[idx] = 1'b0;
      tick();
      step(1);
      chk("R7 no request during service", irq_req, 0);
      reti = 1'b1;
      @(negedge clk);
      reti = 1'b0;
      chk("R7 reti ends service", in_service, 0);
   endtask

   // Monitor: acknowledges a request and compares the grant with the queue.
   initial begin
      irq_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (auto_ack && irq_req) begin
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            if (exp_q.size() == 0) begin
               chk("R6 unexpected grant", irq_vec, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk("R4 granted vector", irq_vec, 3 + 8 * e);
               chk("R6 clear pulse", src_clr, 1 << e);
               chk("R6 request drops", irq_req, 0);
               @(negedge clk);
               chk("R6 clear pulse one clock", src_clr, 0);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mc_tick = 1'b0; en_wr = 1'b0; en_wdata = '0;
      src_flag = '0; tb_run_wr = 1'b0; tb_run_wdata = 1'b0;
      tb_flag_clr = 1'b0; reti = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 irq_req", irq_req, 0);
      chk("R1 irq_vec", irq_vec, 0);
      chk("R1 en_q", en_q, 0);
      chk("R1 tb_cnt", tb_cnt, 0);
      chk("R1 tb_flag", tb_flag, 0);
      chk("R1 in_service", in_service, 0);
      chk("R1 src_clr", src_clr, 0);
      auto_ack = 1'b1;

      // R2: writable bits and reserved bits
      wr_en(8'hFF);
      chk("R2 reserved bits read zero", en_q, 8'h8F);
      wr_en(8'h70);
      chk("R2 reserved-only write", en_q, 8'h00);

      // R3: global enable off
      wr_en(8'h0F);
      src_flag = 3'b111;
      tick();
      step(2);
      chk("R3 no request with EA=0", irq_req, 0);
      chk("R3 no service with EA=0", in_service, 0);

      // R5: enabling EA does not raise a request before a strobe
      wr_en(8'h8F);
      step(2);
      chk("R5 no request before strobe", irq_req, 0);

      // R4: all three external flags pending
      serve(0, "R4 line0 first");
      serve(1, "R4 timer second");
      serve(2, "R4 line1 third");
      chk("R6 scoreboard drained", exp_q.size(), 0);

      // R12: line 0 flagged but disabled
      wr_en(8'h82);
      src_flag = 3'b011;
      serve(1, "R12 enabled timer only");
      tick();
      step(2);
      chk("R12 disabled source ignored", irq_req, 0);
      src_flag = '0;

      // R8 / R9: time base counting, holding, stopping
      wr_en(8'h80);
      wr_run(1'b1);
      chk("R8 count starts at zero", tb_cnt, 0);
      tick(); tick(); tick();
      chk("R8 three strobes", tb_cnt, 3);
      step(5);
      chk("R8 holds between strobes", tb_cnt, 3);
      wr_run(1'b0);
      chk("R9 stop clears count", tb_cnt, 0);
      tick();
      chk("R9 stopped count stays zero", tb_cnt, 0);

      // R10: terminal count carry
      wr_run(1'b1);
      for (int i = 0; i < 31; i++) tick();
      chk("R10 count at max", tb_cnt, 31);
      chk("R10 flag still low", tb_flag, 0);
      tick();
      chk("R10 wrap to zero", tb_cnt, 0);
      chk("R10 flag set", tb_flag, 1);
      step(1);
      chk("R12 time base disabled no request", irq_req, 0);

      // R11: dedicated clear
      tb_flag_clr = 1'b1;
      @(negedge clk);
      tb_flag_clr = 1'b0;
      chk("R11 clear input", tb_flag, 0);

      // R4 lowest pair, then R11 clear by grant
      wr_en(8'h8C);
      for (int i = 0; i < 32; i++) tick();
      chk("R10 second wrap flag", tb_flag, 1);
      src_flag[2] = 1'b1;
      serve(2, "R4 line1 before time base");
      serve(3, "R4 time base last");
      chk("R11 grant clears flag", tb_flag, 0);
      chk("R6 scoreboard drained at end", exp_q.size(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule